// File: doc/BRIEF.md
# Pixel-to-Palette Address Former

This block sits in a pseudo-color video pipeline, between the pixel source and the color lookup table. For each pixel that arrives with its valid strobe, it ANDs the pixel bits with a programmable read mask. It then builds the lookup address. The low part of the address comes from the masked pixel and the high part from a programmable page register. Where the split falls depends on how many bit planes are active. The address appears one clock later with its own valid flag.

A second job of the block is to pick the palette data width (8-bit or 6-bit). By default the width follows an external pin. Software can set an override bit, and then a register bit decides the width and the pin has no effect. Four configuration registers are written through a small indexed write port: the read mask, the page, the plane count and the control bits.

Top module: `pal_addr_former`

## Requirements
- R1: After synchronous reset (`rst` high), the output is `addr_valid`=0 and `pal_addr`=0x00. The read mask is 0xFF, the page is 0x00, the plane code is 00 (8 planes) and both control bits are 0.
- R2: With plane code 00 (8 planes), the address one cycle after a valid pixel equals pixel AND mask on all eight bits. The page is not used.
- R3: With plane code 01 (4 planes), address bits 7..4 equal page bits 7..4 and bits 3..0 equal (pixel AND mask) bits 3..0.
- R4: With plane code 10 (2 planes), address bits 7..2 equal page bits 7..2 and bits 1..0 equal (pixel AND mask) bits 1..0.
- R5: With plane code 11 (1 plane), address bits 7..1 equal page bits 7..1 and bit 0 equals (pixel AND mask) bit 0.
- R6: The mask is applied before the page bits are inserted. A mask of 0x00 clears the pixel-derived bits and leaves the page-derived bits as written.
- R7: `addr_valid` is `pix_valid` delayed by one clock. In a cycle where `pix_valid` is low, `pal_addr` holds its previous value on the next clock.
- R8: When control bit 2 is 1, `w8_sel` equals control bit 3 and changes on `w8_pin` have no effect.
- R9: When control bit 2 is 0 (the reset state), `w8_sel` follows `w8_pin` combinationally.
- R10: A register is written on the clock edge where `wr_en` is high. Index 0 is the mask, 1 the page, 2 the plane code (data bits 1..0) and 3 the control register (bits 2 and 3). A pixel presented in the same cycle as the write uses the old value, and the next pixel uses the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 8 | Pixel bits |
| pix_valid | input | 1 | Pixel strobe |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 2 | Register index |
| wr_data | input | 8 | Register write data |
| w8_pin | input | 1 | External width select, 1 = 8-bit |
| pal_addr | output | 8 | Registered palette address |
| addr_valid | output | 1 | Valid flag aligned with `pal_addr` |
| w8_sel | output | 1 | Effective width select, 1 = 8-bit |

## Verification
Some behaviour is checked by the assertions on every cycle. They cover the one-cycle valid alignment and the hold of the address between pixels. They check that the full-width mode passes the masked pixel straight through, and that the page bits reach the upper address field in the 4-plane and 1-plane modes. They also check that the width select ignores pin changes under override and tracks them otherwise. Other behaviour only the bench scenarios can show. These are the exact low-bit values in every plane mode, swept over all 256 pixels with different masks and pages. They also include the reset values of the registers and the old-versus-new ordering when a write and a pixel share a cycle.

// File: rtl/pal_addr_pkg.sv
package pal_addr_pkg;

    typedef enum logic [1:0] {
        PL_8 = 2'b00,
        PL_4 = 2'b01,
        PL_2 = 2'b10,
        PL_1 = 2'b11
    } plane_e;

    typedef enum logic [1:0] {
        IDX_MASK   = 2'd0,
        IDX_PAGE   = 2'd1,
        IDX_PLANES = 2'd2,
        IDX_CTRL   = 2'd3
    } reg_idx_e;

    localparam int CTRL_OVR_BIT = 2;
    localparam int CTRL_SEL_BIT = 3;

endpackage

// File: rtl/pal_cfg_regs.sv
module pal_cfg_regs
    import pal_addr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_idx,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cfg_mask,
    output logic [W-1:0] cfg_page,
    output plane_e       cfg_planes,
    output logic         cfg_ovr,
    output logic         cfg_sel
);

    reg_idx_e idx;
    assign idx = reg_idx_e'(wr_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_mask   <= '1;
            cfg_page   <= '0;
            cfg_planes <= PL_8;
            cfg_ovr    <= 1'b0;
            cfg_sel    <= 1'b0;
        end else if (wr_en) begin
            unique case (idx)
                IDX_MASK:   cfg_mask   <= wr_data;
                IDX_PAGE:   cfg_page   <= wr_data;
                IDX_PLANES: cfg_planes <= plane_e'(wr_data[1:0]);
                IDX_CTRL: begin
                    cfg_ovr <= wr_data[CTRL_OVR_BIT];
                    cfg_sel <= wr_data[CTRL_SEL_BIT];
                end
            endcase
        end
    end

endmodule

// File: rtl/pal_addr_merge.sv
module pal_addr_merge
    import pal_addr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] pix,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] page,
    input  plane_e       planes,
    output logic [W-1:0] addr
);

    localparam int N4 = W >> 1;
    localparam int N2 = W >> 2;
    localparam int N1 = W >> 3;

    localparam logic [W-1:0] LOW_8 = '1;
    localparam logic [W-1:0] LOW_4 = {{(W-N4){1'b0}}, {N4{1'b1}}};
    localparam logic [W-1:0] LOW_2 = {{(W-N2){1'b0}}, {N2{1'b1}}};
    localparam logic [W-1:0] LOW_1 = {{(W-N1){1'b0}}, {N1{1'b1}}};

    logic [W-1:0] low_m;
    logic [W-1:0] masked;

    always_comb begin
        unique case (planes)
            PL_8: low_m = LOW_8;
            PL_4: low_m = LOW_4;
            PL_2: low_m = LOW_2;
            PL_1: low_m = LOW_1;
        endcase
    end

    assign masked = pix & mask;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign addr[i] = low_m[i] ? masked[i] : page[i];
    end

endmodule

// File: rtl/pal_addr_stage.sv
module pal_addr_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_addr,
    output logic [W-1:0] out_addr,
    output logic         out_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_addr  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_addr <= in_addr;
            end
        end
    end

endmodule

// File: rtl/pal_addr_former.sv
module pal_addr_former
    import pal_addr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pix_in,
    input  logic              pix_valid,
    input  logic              wr_en,
    input  logic [1:0]        wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              w8_pin,
    output logic [ADDR_W-1:0] pal_addr,
    output logic              addr_valid,
    output logic              w8_sel
);

    logic [ADDR_W-1:0] cfg_mask;
    logic [ADDR_W-1:0] cfg_page;
    plane_e            cfg_planes;
    logic              cfg_ovr;
    logic              cfg_sel;
    logic [ADDR_W-1:0] next_addr;

    pal_cfg_regs #(.W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .cfg_mask   (cfg_mask),
        .cfg_page   (cfg_page),
        .cfg_planes (cfg_planes),
        .cfg_ovr    (cfg_ovr),
        .cfg_sel    (cfg_sel)
    );

    pal_addr_merge #(.W(ADDR_W)) u_merge (
        .pix    (pix_in),
        .mask   (cfg_mask),
        .page   (cfg_page),
        .planes (cfg_planes),
        .addr   (next_addr)
    );

    pal_addr_stage #(.W(ADDR_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (pix_valid),
        .in_addr   (next_addr),
        .out_addr  (pal_addr),
        .out_valid (addr_valid)
    );

    assign w8_sel = cfg_ovr ? cfg_sel : w8_pin;

endmodule

// File: rtl/pal_addr_former_chk.sv
module pal_addr_former_chk
    import pal_addr_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] pix_in,
    input logic         pix_valid,
    input logic         w8_pin,
    input logic         w8_sel,
    input logic [W-1:0] pal_addr,
    input logic         addr_valid,
    input logic [W-1:0] cfg_mask,
    input logic [W-1:0] cfg_page,
    input plane_e       cfg_planes,
    input logic         cfg_ovr,
    input logic         cfg_sel
);

    assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
        pix_valid |=> addr_valid);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !pix_valid |=> (!addr_valid && $stable(pal_addr)));

    assert_full_width_R2: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cfg_planes == PL_8) |=> pal_addr == $past(pix_in & cfg_mask));

    assert_page_upper4_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cfg_planes == PL_4) |=> pal_addr[W-1:W/2] == $past(cfg_page[W-1:W/2]));

    assert_page_upper1_R5: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && cfg_planes == PL_1) |=> pal_addr[W-1:1] == $past(cfg_page[W-1:1]));

    assert_pin_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_ovr && $past(cfg_ovr) && $stable(cfg_sel)) |-> $stable(w8_sel));

    assert_pin_tracked_R9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ovr && !$past(cfg_ovr) && (w8_pin != $past(w8_pin))) |-> (w8_sel != $past(w8_sel)));

endmodule

bind pal_addr_former pal_addr_former_chk #(.W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_in     (pix_in),
    .pix_valid  (pix_valid),
    .w8_pin     (w8_pin),
    .w8_sel     (w8_sel),
    .pal_addr   (pal_addr),
    .addr_valid (addr_valid),
    .cfg_mask   (cfg_mask),
    .cfg_page   (cfg_page),
    .cfg_planes (cfg_planes),
    .cfg_ovr    (cfg_ovr),
    .cfg_sel    (cfg_sel)
);

// File: tb/sim_pal_addr_former.sv
`timescale 1ns/1ps
module sim_pal_addr_former;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_in = 8'h00;
    logic       pix_valid = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_idx = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic       w8_pin = 1'b0;
    logic [7:0] pal_addr;
    logic       addr_valid;
    logic       w8_sel;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pal_addr_former #(.ADDR_W(8)) u0 (
        .clk        (clk),
        .rst        (rst),
        .pix_in     (pix_in),
        .pix_valid  (pix_valid),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .w8_pin     (w8_pin),
        .pal_addr   (pal_addr),
        .addr_valid (addr_valid),
        .w8_sel     (w8_sel)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [7:0] p, input logic [7:0] m,
                                         input logic [7:0] pg, input int code);
        int nb;
        logic [7:0] low;
        nb  = 8 >> code;
        low = 8'(((1 << nb) - 1));
        return (p & m & low) | (pg & ~low);
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input int idx, input logic [7:0] d);
        wr_en = 1'b1;
        wr_idx = 2'(idx);
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] p, input logic [7:0] exp, input string tag);
        pix_in = p;
        pix_valid = 1'b1;
        @(negedge clk);
        check(tag, int'(pal_addr), int'(exp));
        pix_valid = 1'b0;
    endtask

    task automatic sweep(input int code, input logic [7:0] m, input logic [7:0] pg, input string tag);
        wr(2, 8'(code));
        wr(0, m);
        wr(1, pg);
        for (int p = 0; p < 256; p++) begin
            send(8'(p), model(8'(p), m, pg, code), tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the outputs
        check("R1 valid", int'(addr_valid), 0);
        check("R1 addr", int'(pal_addr), 0);
        // R1/R9: default width follows pin
        w8_pin = 1'b1; #1;
        check("R9 pin high", int'(w8_sel), 1);
        w8_pin = 1'b0; #1;
        check("R9 pin low", int'(w8_sel), 0);
        // R1: default mask 0xFF, 8 planes, page 0x00
        send(8'hA5, 8'hA5, "R1 default regs");

        sweep(0, 8'hFF, 8'h00, "R2 full");
        sweep(0, 8'h3C, 8'hFF, "R2 masked");
        sweep(1, 8'hFF, 8'h50, "R3 four");
        sweep(1, 8'h0A, 8'hE7, "R3 four masked");
        sweep(2, 8'hFF, 8'h94, "R4 two");
        sweep(2, 8'h01, 8'h6B, "R4 two masked");
        sweep(3, 8'hFF, 8'hC8, "R5 one");
        sweep(3, 8'hFE, 8'h37, "R5 one masked");
        // R6: zero mask leaves only page bits
        sweep(1, 8'h00, 8'hFF, "R6 zero mask");
        send(8'hFF, 8'hF0, "R6 page kept");

        // R7: hold and valid alignment
        wr(0, 8'hFF);
        send(8'h3D, 8'hFD, "R7 load");
        check("R7 valid high", int'(addr_valid), 1);
        pix_in = 8'h42;
        @(negedge clk);
        check("R7 valid low", int'(addr_valid), 0);
        check("R7 hold", int'(pal_addr), 8'hFD);

        // R10: page write concurrent with a pixel (mode 4 planes, page 0xFF)
        wr_en = 1'b1; wr_idx = 2'd1; wr_data = 8'hA0;
        pix_in = 8'h07; pix_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; pix_valid = 1'b0;
        check("R10 old page", int'(pal_addr), 8'hF7);
        send(8'h07, 8'hA7, "R10 new page");

        // R8: override
        wr(3, 8'h0C);
        w8_pin = 1'b0; #1;
        check("R8 sel=1 pin0", int'(w8_sel), 1);
        w8_pin = 1'b1; #1;
        check("R8 sel=1 pin1", int'(w8_sel), 1);
        @(negedge clk);
        wr(3, 8'h04);
        check("R8 sel=0 pin1", int'(w8_sel), 0);
        w8_pin = 1'b0; #1;
        check("R8 sel=0 pin0", int'(w8_sel), 0);
        @(negedge clk);
        // R9: override cleared, bit 3 alone does nothing
        wr(3, 8'h08);
        w8_pin = 1'b1; #1;
        check("R9 release high", int'(w8_sel), 1);
        w8_pin = 1'b0; #1;
        check("R9 release low", int'(w8_sel), 0);

        // R1: reset restores register defaults
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset valid", int'(addr_valid), 0);
        send(8'h5A, 8'h5A, "R1 regs after reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule